// File: doc/BRIEF.md
# Four-Phase Dual-Chopper Demodulator

This block sequences and demodulates a sensor read out under two stacked chopping schemes. One control flips the bias-current spinning direction. The other flips the polarity of an on-chip reference excitation. The two controls step through a repeating cycle of four phases. In each phase the amplifier output is the spin sign times the sum of the external signal and the coil sign times the reference, plus an offset that is never chopped.

The block takes one signed digitized amplifier sample per phase. It keeps three running sums, one per sign pattern, so that a single cycle yields four times the external signal, four times the reference and four times the offset. When the cycle ends, it presents the three sums together with a one-clock valid strobe.

A phase strobe from a rate generator (nominally 1 MHz) advances the sequence. The new polarities leave the block one clock before the sample of that phase is accepted, which gives the analog front end time to settle.

Top module: `quad_phase_demod`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the block enters the reset state. In that state `spin_pol` = 1, `coil_pol` = 1 (the phase-1 polarities), all three sums read 0 and `out_valid` is 0.
- R2: A polarity bit of 1 means positive and 0 means negative. In phases 1, 2, 3, 4 `spin_pol` is 1, 0, 1, 0 and `coil_pol` is 1, 1, 0, 0. The first `phase_en` strobe after reset starts phase 1. Each later strobe starts the next phase, and phase 4 is followed by phase 1.
- R3: The polarities change only on the clock edge at which `phase_en` is sampled high, so the new values are visible in the following cycle. They hold steady at all other times.
- R4: A sample is accepted only when `sample_valid` is high in the clock cycle right after a `phase_en` strobe cycle. A sample offered at any other time, including during the strobe cycle itself, is ignored and leaves every sum unchanged.
- R5: `sig_sum` = s1 − s2 + s3 − s4, where sk is the sample accepted in phase k as a 16-bit two's-complement value.
- R6: `ref_sum` = s1 − s2 − s3 + s4.
- R7: `off_sum` = s1 + s2 + s3 + s4.
- R8: The sums restart at the strobe that begins phase 1. A phase with no accepted sample contributes zero, and nothing carries over from an earlier cycle.
- R9: `out_valid` is high for exactly one clock, in the cycle after the phase-4 sample is accepted, and the three sums hold that cycle's results in that same cycle. If no phase-4 sample is accepted, there is no pulse.
- R10: The 18-bit signed sums represent every combination of full-scale samples without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_en | input | 1 | One-clock strobe that starts the next phase |
| sample_valid | input | 1 | Qualifies `sample` |
| sample | input | 16 | Two's-complement amplifier sample |
| spin_pol | output | 1 | Spinning-current polarity (1 = positive) |
| coil_pol | output | 1 | Reference-coil polarity (1 = positive) |
| sig_sum | output | 18 | Signed external-signal sum |
| ref_sum | output | 18 | Signed reference sum |
| off_sum | output | 18 | Signed offset sum |
| out_valid | output | 1 | One-clock strobe marking a finished cycle |

## Verification
The polarity bits are due one clock after the edge that samples `phase_en`. A sample counts only at the edge that closes the cycle right after the strobe. `out_valid` and the three sums are due one clock after that acceptance edge. The bench drives every input on the falling edge and reads each result at the next falling edge after the rising edge that produces it. It also checks that the polarities are still unchanged during the strobe cycle itself. During the idle gaps it feeds junk samples and confirms that the polarities, the strobe and the finished sums stay put.

// File: rtl/qpd_pkg.sv
package qpd_pkg;
  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned PH_W       = $clog2(NUM_PHASES);
  localparam int unsigned NUM_CH     = 3;

  typedef logic [PH_W-1:0] phase_t;

  // Bit k set: the sample of phase k+1 is subtracted for channel ch.
  // Channel 0 follows the spin sign, 1 the spin*coil product, 2 is all plus.
  function automatic logic [NUM_PHASES-1:0] neg_mask(input int ch);
    case (ch)
      0:       return 4'b1010;
      1:       return 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic spin_of(input phase_t ph);
    return ~ph[0];
  endfunction

  function automatic logic coil_of(input phase_t ph);
    return ~ph[1];
  endfunction
endpackage

// File: rtl/qpd_seq.sv
module qpd_seq
  import qpd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   phase_en,
  input  logic   sample_valid,
  output phase_t ph,
  output logic   spin_pol,
  output logic   coil_pol,
  output logic   acc_en,
  output logic   fresh,
  output logic   done
);
  logic   started;
  logic   win;
  logic   armed;
  phase_t next_ph;

  assign next_ph = started ? phase_t'(ph + 1'b1) : '0;
  assign acc_en  = win & sample_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= '0;
      started  <= 1'b0;
      win      <= 1'b0;
      spin_pol <= 1'b1;
      coil_pol <= 1'b1;
      fresh    <= 1'b1;
      done     <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed <= 1'b1;
      win   <= phase_en;
      done  <= acc_en && (ph == phase_t'(NUM_PHASES - 1));
      if (phase_en) begin
        ph       <= next_ph;
        started  <= 1'b1;
        spin_pol <= spin_of(next_ph);
        coil_pol <= coil_of(next_ph);
      end
      if (phase_en && (next_ph == '0)) fresh <= 1'b1;
      else if (acc_en)                 fresh <= 1'b0;
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst || !armed)
    (phase_en && started) |=> (ph == phase_t'($past(ph) + 1'b1))); // R2

  AST_POL_STABLE: assert property (@(posedge clk) disable iff (rst || !armed)
    !phase_en |=> ($stable(spin_pol) && $stable(coil_pol))); // R3
endmodule

// File: rtl/qpd_accum.sv
module qpd_accum
  import qpd_pkg::*;
#(
  parameter int unsigned              SAMPLE_W = 16,
  parameter int unsigned              SUM_W    = SAMPLE_W + 2,
  parameter logic [NUM_PHASES-1:0]    NEG_MASK = '0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       acc_en,
  input  logic                       fresh,
  input  phase_t                     ph,
  input  logic [SAMPLE_W-1:0]        sample,
  output logic signed [SUM_W-1:0]    sum
);
  localparam int unsigned EXT_W = SUM_W - SAMPLE_W;

  logic signed [SUM_W-1:0] ext;
  logic signed [SUM_W-1:0] term;
  logic signed [SUM_W-1:0] base;
  logic                    armed;

  assign ext  = {{EXT_W{sample[SAMPLE_W-1]}}, sample};
  assign term = NEG_MASK[ph] ? -ext : ext;
  assign base = fresh ? '0 : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (acc_en) sum <= base + term;
    end
  end

  AST_IGNORED_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
    !acc_en |=> $stable(sum)); // R4
endmodule

// File: rtl/quad_phase_demod.sv
module quad_phase_demod
  import qpd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  phase_en,
  input  logic                                  sample_valid,
  input  logic [SAMPLE_W-1:0]                   sample,
  output logic                                  spin_pol,
  output logic                                  coil_pol,
  output logic signed [SAMPLE_W+PH_W-1:0]       sig_sum,
  output logic signed [SAMPLE_W+PH_W-1:0]       ref_sum,
  output logic signed [SAMPLE_W+PH_W-1:0]       off_sum,
  output logic                                  out_valid
);
  localparam int unsigned SUM_W = SAMPLE_W + PH_W;

  phase_t                  ph;
  logic                    acc_en;
  logic                    fresh;
  logic                    armed;
  logic signed [SUM_W-1:0] sums [NUM_CH];

  qpd_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .phase_en     (phase_en),
    .sample_valid (sample_valid),
    .ph           (ph),
    .spin_pol     (spin_pol),
    .coil_pol     (coil_pol),
    .acc_en       (acc_en),
    .fresh        (fresh),
    .done         (out_valid)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qpd_accum #(
      .SAMPLE_W (SAMPLE_W),
      .SUM_W    (SUM_W),
      .NEG_MASK (neg_mask(c))
    ) u_acc (
      .clk    (clk),
      .rst    (rst),
      .acc_en (acc_en),
      .fresh  (fresh),
      .ph     (ph),
      .sample (sample),
      .sum    (sums[c])
    );
  end

  assign sig_sum = sums[0];
  assign ref_sum = sums[1];
  assign off_sum = sums[2];

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid |=> !out_valid); // R9

  AST_VALID_CONTEXT: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid |-> ($past(sample_valid) && !$past(spin_pol) && !$past(coil_pol))); // R9

  AST_SUM_PARITY: assert property (@(posedge clk) disable iff (rst || !armed)
    out_valid |-> ((sig_sum[0] == ref_sum[0]) && (off_sum[0] == sig_sum[0]))); // R5
endmodule

// File: tb/tb_quad_phase_demod.sv
module tb_quad_phase_demod;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase_en = 1'b0;
  logic sample_valid = 1'b0;
  logic [15:0] sample = '0;
  logic spin_pol, coil_pol, out_valid;
  logic signed [17:0] sig_sum, ref_sum, off_sum;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  int smp [4];
  bit vld [4];
  int prev_k = 0;

  always #4 clk = ~clk;

  quad_phase_demod dut (
    .clk(clk), .rst(rst), .phase_en(phase_en), .sample_valid(sample_valid),
    .sample(sample), .spin_pol(spin_pol), .coil_pol(coil_pol),
    .sig_sum(sig_sum), .ref_sum(ref_sum), .off_sum(off_sum), .out_valid(out_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sgn(input int ch, input int k);
    if (ch == 2) return 1;
    if (ch == 0) return (k % 2 == 0) ? 1 : -1;
    return (k == 0 || k == 3) ? 1 : -1;
  endfunction

  function automatic int exp_sum(input int ch);
    int acc = 0;
    for (int k = 0; k < 4; k++) if (vld[k]) acc += sgn(ch, k) * smp[k];
    return acc;
  endfunction

  task automatic chk_sums(input string tag);
    chk({tag, " R5 sig_sum"}, int'(sig_sum), exp_sum(0));
    chk({tag, " R6 ref_sum"}, int'(ref_sum), exp_sum(1));
    chk({tag, " R7 off_sum"}, int'(off_sum), exp_sum(2));
  endtask

  task automatic run_phase(input int k, input int gap);
    @(negedge clk);
    chk("R3 spin before strobe", int'(spin_pol), int'(prev_k % 2 == 0));
    chk("R3 coil before strobe", int'(coil_pol), int'(prev_k < 2));
    phase_en = 1'b1;
    sample_valid = 1'($urandom_range(0, 1));
    sample = 16'($urandom);
    @(negedge clk);
    phase_en = 1'b0;
    sample_valid = vld[k];
    sample = 16'(smp[k]);
    chk("R2 spin_pol", int'(spin_pol), int'(k % 2 == 0));
    chk("R2 coil_pol", int'(coil_pol), int'(k < 2));
    @(negedge clk);
    sample_valid = 1'b0;
    sample = 16'($urandom);
    if (k == 3) begin
      chk("R9 out_valid at end", int'(out_valid), int'(vld[3]));
      if (vld[3]) chk_sums("R8");
    end else begin
      chk("R9 out_valid mid-cycle", int'(out_valid), 0);
    end
    prev_k = k;
    for (int g = 0; g < gap; g++) begin
      sample_valid = 1'($urandom_range(0, 1));
      sample = 16'($urandom);
      @(negedge clk);
      chk("R3 spin idle", int'(spin_pol), int'(k % 2 == 0));
      chk("R9 out_valid idle", int'(out_valid), 0);
      if (k == 3 && vld[3]) chk_sums("R4 idle hold");
      sample_valid = 1'b0;
    end
  endtask

  task automatic run_cycle(input int gapmax);
    for (int k = 0; k < 4; k++) run_phase(k, $urandom_range(0, gapmax));
  endtask

  task automatic load(input int a, input int b, input int c, input int d);
    smp[0] = a; smp[1] = b; smp[2] = c; smp[3] = d;
    for (int k = 0; k < 4; k++) vld[k] = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 spin_pol", int'(spin_pol), 1);
    chk("R1 coil_pol", int'(coil_pol), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 sig_sum", int'(sig_sum), 0);
    chk("R1 ref_sum", int'(ref_sum), 0);
    chk("R1 off_sum", int'(off_sum), 0);
    rst = 1'b0;
    prev_k = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();

    load(100, 20, 3, -7);
    run_cycle(2);
    load(-500, 1200, 77, 4000);
    run_cycle(0);

    // R10 full-scale corners
    load(32767, -32768, 32767, -32768);
    run_cycle(1);
    load(-32768, 32767, 32767, -32768);
    run_cycle(1);
    load(-32768, -32768, -32768, -32768);
    run_cycle(1);
    chk("R10 off_sum floor", int'(off_sum), -131072);

    // R8 missing first sample, then R9 missing last sample, then clean
    load(11, 22, 33, 44);
    vld[0] = 1'b0;
    run_cycle(1);
    load(5, 6, 7, 8);
    vld[3] = 1'b0;
    run_cycle(1);
    load(-9, 13, -300, 2);
    run_cycle(1);

    // R1 reset in mid-cycle
    load(1000, 2000, 3000, 4000);
    run_phase(0, 1);
    run_phase(1, 0);
    @(negedge clk);
    do_reset();
    load(-1, -2, -3, -4);
    run_cycle(1);

    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < 4; k++) begin
        smp[k] = int'($signed(16'($urandom)));
        vld[k] = ($urandom_range(0, 5) != 0);
      end
      run_cycle(3);
    end

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule